// File: doc/BRIEF.md
# Threshold-Flagged Sample Queue

This block sits between a conversion sequencer and a host processor and buffers converted samples in a first-in, first-out store. The store holds 16 words of 10 bits. The sequencer pushes one word per write strobe, and the host pops one word per read strobe. The popped word appears on the read data output on the clock after the strobe.

The block does not announce data as soon as one word is present. It drives a data-available flag once the number of stored words reaches a threshold that the host selects with a two-bit code. Two further controls set the flag's form. It can be active-high or active-low, and it can follow the fill state as a level or mark each upward crossing with a single clock pulse. Sticky status bits record writes dropped because the queue was full and reads attempted while it was empty. A synchronous clear input empties the queue and clears the status bits.

Top module: `trig_fifo`

## Requirements
- R1: After reset, `fill_count` is 0, `overflow` and `underflow` are 0, `rd_data` is 0, and `data_av` is at its inactive level.
- R2: Words are read out in the order they were written. The word popped by a read strobe appears on `rd_data` after the clock edge that takes the strobe.
- R3: A write strobe while `fill_count` is 16 is dropped, leaves the contents unchanged, and sets `overflow`. `overflow` stays set until clear or reset.
- R4: A read strobe while the queue is empty leaves `rd_data` unchanged and sets `underflow`. `underflow` stays set until clear or reset.
- R5: `trig_sel` selects the threshold: code 0 selects 1 word, code 1 selects 4, code 2 selects 8 and code 3 selects 14.
- R6: With `av_pulse_mode`=0, the flag is active in every cycle in which `fill_count` is at or above the threshold, and inactive otherwise.
- R7: With `av_pulse_mode`=1, the flag is active for exactly one cycle each time `fill_count` rises from below the threshold to at or above it.
- R8: With `av_active_low`=1, the active flag level is 0 and the inactive level is 1. With `av_active_low`=0, the active level is 1.
- R9: A `fifo_clr` pulse, sampled on a clock edge, empties the queue, sets `fill_count` and `rd_data` to 0 and clears both sticky bits.
- R10: `fill_count` changes on the clock edge that takes a strobe. A read and a write accepted in the same cycle leave the count unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| fifo_clr | input | 1 | Synchronous clear of contents and status |
| wr_en | input | 1 | Write strobe from the sequencer |
| wr_data | input | 10 | Word to store |
| rd_en | input | 1 | Read strobe from the host |
| rd_data | output | 10 | Last popped word |
| trig_sel | input | 2 | Threshold code (0:1, 1:4, 2:8, 3:14 words) |
| av_active_low | input | 1 | 1 makes the flag active low |
| av_pulse_mode | input | 1 | 1 gives a one-cycle pulse on crossing; 0 gives a level |
| data_av | output | 1 | Data-available flag |
| fill_count | output | 5 | Number of stored words, 0 to 16 |
| overflow | output | 1 | Sticky: a write was dropped while full |
| underflow | output | 1 | Sticky: a read was made while empty |

## Verification
The hardest case to reach is the pulse form crossing the threshold a second time. The occupancy has to fall below the threshold and then climb back to it, and the bench must show that no pulse appears while the count stays above it. The directed pulse test writes up to threshold 4, idles, writes past it, drains two words and refills one, checking the flag in each cycle. The full and empty edges are reached by writing 17 words and then reading 17 times. The bench confirms that the dropped word never appears on the output and that the output holds during the empty read.

// File: rtl/trig_fifo_pkg.sv
package trig_fifo_pkg;
   typedef logic [1:0] trig_code_t;

   // threshold table lookup, computed from four parameters
   function automatic int unsigned level_of(input trig_code_t code,
                                            input int unsigned l0, input int unsigned l1,
                                            input int unsigned l2, input int unsigned l3);
      case (code)
         2'd0:    return l0;
         2'd1:    return l1;
         2'd2:    return l2;
         default: return l3;
      endcase
   endfunction
endpackage

// File: rtl/tf_ctrl.sv
module tf_ctrl #(
   parameter int DEPTH = 16,
   localparam int CW = $clog2(DEPTH + 1)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          clr,
   input  logic          wr_en,
   input  logic          rd_en,
   output logic          push,
   output logic          pop,
   output logic [CW-1:0] count,
   output logic          ovf,
   output logic          unf
);
   logic full, empty;

   assign full  = (count == CW'(DEPTH));
   assign empty = (count == '0);
   assign push  = wr_en && !full && !clr;
   assign pop   = rd_en && !empty && !clr;

   always_ff @(posedge clk) begin
      if (!rst_n || clr) begin
         count <= '0;
         ovf   <= 1'b0;
         unf   <= 1'b0;
      end else begin
         count <= count + CW'(push) - CW'(pop);
         if (wr_en && full)  ovf <= 1'b1;
         if (rd_en && empty) unf <= 1'b1;
      end
   end

   assert_cnt_bound_R10: assert property (@(posedge clk) disable iff (!rst_n)
      count <= CW'(DEPTH));
   assert_no_overflow_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (full && wr_en && !rd_en && !clr) |=> (ovf && count == CW'(DEPTH)));
   assert_underflow_sticky_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (empty && rd_en && !clr) |=> unf);
   assert_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> (count == '0 && !ovf && !unf));
endmodule

// File: rtl/tf_store.sv
module tf_store #(
   parameter int DATA_W = 10,
   parameter int DEPTH  = 16,
   localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clr,
   input  logic              push,
   input  logic              pop,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] rdata
);
   logic [DATA_W-1:0] mem [DEPTH];
   logic [AW-1:0]     wp, rp, wp_n, rp_n;

   generate
      if (DEPTH == (1 << AW)) begin : g_pow2
         assign wp_n = wp + 1'b1;
         assign rp_n = rp + 1'b1;
      end else begin : g_wrap
         assign wp_n = (wp == AW'(DEPTH - 1)) ? '0 : wp + 1'b1;
         assign rp_n = (rp == AW'(DEPTH - 1)) ? '0 : rp + 1'b1;
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (push) mem[wp] <= wdata;
   end

   always_ff @(posedge clk) begin
      if (!rst_n || clr) begin
         wp    <= '0;
         rp    <= '0;
         rdata <= '0;
      end else begin
         if (push) wp <= wp_n;
         if (pop) begin
            rp    <= rp_n;
            rdata <= mem[rp];
         end
      end
   end

   assert_hold_when_idle_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (!pop && !clr) |=> $stable(rdata));
endmodule

// File: rtl/tf_flag.sv
module tf_flag
   import trig_fifo_pkg::*;
#(
   parameter int DEPTH = 16,
   parameter int LVL0  = 1,
   parameter int LVL1  = 4,
   parameter int LVL2  = 8,
   parameter int LVL3  = 14,
   localparam int CW = $clog2(DEPTH + 1)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          clr,
   input  logic [CW-1:0] count,
   input  trig_code_t    sel,
   input  logic          act_low,
   input  logic          pulse_mode,
   output logic          flag
);
   logic [CW-1:0] thresh;
   logic          hit, hit_q, raw;

   assign thresh = CW'(level_of(sel, LVL0, LVL1, LVL2, LVL3));
   assign hit    = (count >= thresh);

   always_ff @(posedge clk) begin
      if (!rst_n || clr) hit_q <= 1'b0;
      else               hit_q <= hit;
   end

   assign raw  = pulse_mode ? (hit && !hit_q) : hit;
   assign flag = raw ^ act_low;

   assert_pulse_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (pulse_mode && raw) |=> (!pulse_mode || !raw));
   assert_av_needs_data_R6: assert property (@(posedge clk) disable iff (!rst_n)
      raw |-> (count != '0));
endmodule

// File: rtl/trig_fifo.sv
module trig_fifo
   import trig_fifo_pkg::*;
#(
   parameter int DATA_W = 10,
   parameter int DEPTH  = 16,
   parameter int LVL0   = 1,
   parameter int LVL1   = 4,
   parameter int LVL2   = 8,
   parameter int LVL3   = 14,
   localparam int CW = $clog2(DEPTH + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              fifo_clr,
   input  logic              wr_en,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              rd_en,
   output logic [DATA_W-1:0] rd_data,
   input  logic [1:0]        trig_sel,
   input  logic              av_active_low,
   input  logic              av_pulse_mode,
   output logic              data_av,
   output logic [CW-1:0]     fill_count,
   output logic              overflow,
   output logic              underflow
);
   generate
      if (DEPTH < 2) begin : g_bad_depth
         $error("trig_fifo: DEPTH must be at least 2");
      end
      if (LVL0 < 1 || LVL1 < 1 || LVL2 < 1 || LVL3 < 1 ||
          LVL0 > DEPTH || LVL1 > DEPTH || LVL2 > DEPTH || LVL3 > DEPTH) begin : g_bad_lvl
         $error("trig_fifo: thresholds must lie in 1..DEPTH");
      end
   endgenerate

   logic push, pop;

   tf_ctrl #(.DEPTH(DEPTH)) u_ctrl (
      .clk(clk), .rst_n(rst_n), .clr(fifo_clr),
      .wr_en(wr_en), .rd_en(rd_en),
      .push(push), .pop(pop), .count(fill_count),
      .ovf(overflow), .unf(underflow));

   tf_store #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_store (
      .clk(clk), .rst_n(rst_n), .clr(fifo_clr),
      .push(push), .pop(pop), .wdata(wr_data), .rdata(rd_data));

   tf_flag #(.DEPTH(DEPTH), .LVL0(LVL0), .LVL1(LVL1), .LVL2(LVL2), .LVL3(LVL3)) u_flag (
      .clk(clk), .rst_n(rst_n), .clr(fifo_clr),
      .count(fill_count), .sel(trig_sel),
      .act_low(av_active_low), .pulse_mode(av_pulse_mode), .flag(data_av));
endmodule

// File: tb/tb_trig_fifo.sv
module tb_trig_fifo;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       fifo_clr = 1'b0, wr_en = 1'b0, rd_en = 1'b0;
   logic [9:0] wr_data = '0;
   logic [9:0] rd_data;
   logic [1:0] trig_sel = 2'd0;
   logic       av_active_low = 1'b0, av_pulse_mode = 1'b0;
   logic       data_av, overflow, underflow;
   logic [4:0] fill_count;
   int         checks = 0, errors = 0;
   bit         done = 1'b0;

   always #5 clk = ~clk;

   trig_fifo dut (
      .clk(clk), .rst_n(rst_n), .fifo_clr(fifo_clr), .wr_en(wr_en), .wr_data(wr_data),
      .rd_en(rd_en), .rd_data(rd_data), .trig_sel(trig_sel),
      .av_active_low(av_active_low), .av_pulse_mode(av_pulse_mode),
      .data_av(data_av), .fill_count(fill_count),
      .overflow(overflow), .underflow(underflow));

   typedef struct packed {
      logic       wr;
      logic       rd;
      logic [9:0] data;
      logic [4:0] cnt;
      logic       av;
      logic       chk_rd;
      logic [9:0] exp_rd;
   } vec_t;

   // threshold 4, level form, active high
   localparam vec_t VEC [8] = '{
      {1'b1, 1'b0, 10'h3A1, 5'd1, 1'b0, 1'b0, 10'h000},
      {1'b1, 1'b0, 10'h0B2, 5'd2, 1'b0, 1'b0, 10'h000},
      {1'b1, 1'b0, 10'h1C3, 5'd3, 1'b0, 1'b0, 10'h000},
      {1'b1, 1'b0, 10'h2D4, 5'd4, 1'b1, 1'b0, 10'h000},
      {1'b1, 1'b1, 10'h0E5, 5'd4, 1'b1, 1'b1, 10'h3A1},
      {1'b0, 1'b1, 10'h000, 5'd3, 1'b0, 1'b1, 10'h0B2},
      {1'b1, 1'b0, 10'h3F6, 5'd4, 1'b1, 1'b0, 10'h000},
      {1'b0, 1'b1, 10'h000, 5'd3, 1'b0, 1'b1, 10'h1C3}
   };

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual %0d expected %0d", tag, act, exp);
      end
   endtask

   task automatic step(input logic w, input logic r, input logic [9:0] d);
      wr_en = w; rd_en = r; wr_data = d;
      @(negedge clk);
      wr_en = 1'b0; rd_en = 1'b0;
   endtask

   task automatic clear();
      fifo_clr = 1'b1;
      @(negedge clk);
      fifo_clr = 1'b0;
   endtask

   function automatic int lvl(input int code);
      case (code)
         0: return 1;
         1: return 4;
         2: return 8;
         default: return 14;
      endcase
   endfunction

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         errors++;
         $display("FAIL watchdog all actual timeout expected completion");
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      // R1 reset state
      check("R1 count", fill_count, 0);
      check("R1 overflow", overflow, 0);
      check("R1 underflow", underflow, 0);
      check("R1 rd_data", rd_data, 0);
      check("R1 data_av", data_av, 0);

      // table walk: R2 order, R6 level, R10 simultaneous
      trig_sel = 2'd1;
      foreach (VEC[i]) begin
         step(VEC[i].wr, VEC[i].rd, VEC[i].data);
         check($sformatf("R10 count vec %0d", i), fill_count, VEC[i].cnt);
         check($sformatf("R6 data_av vec %0d", i), data_av, VEC[i].av);
         if (VEC[i].chk_rd) check($sformatf("R2 rd_data vec %0d", i), rd_data, VEC[i].exp_rd);
      end

      // R9 clear
      clear();
      check("R9 count", fill_count, 0);
      check("R9 rd_data", rd_data, 0);

      // R3 overflow, R5 code 3
      trig_sel = 2'd3;
      for (int k = 0; k < 17; k++) step(1'b1, 1'b0, 10'(100 + k));
      check("R3 count", fill_count, 16);
      check("R3 overflow", overflow, 1);
      check("R5 data_av at 16 code3", data_av, 1);
      for (int k = 0; k < 16; k++) begin
         step(1'b0, 1'b1, '0);
         check("R2 order", rd_data, 100 + k);
      end
      // R4 empty read
      step(1'b0, 1'b1, '0);
      check("R4 rd_data hold", rd_data, 115);
      check("R4 underflow", underflow, 1);
      check("R3 overflow sticky", overflow, 1);
      clear();
      check("R9 overflow cleared", overflow, 0);
      check("R9 underflow cleared", underflow, 0);

      // R5 / R6 threshold sweep
      for (int code = 0; code < 4; code++) begin
         trig_sel = 2'(code);
         clear();
         for (int k = 1; k <= 15; k++) begin
            step(1'b1, 1'b0, 10'(k));
            check($sformatf("R5 code %0d count %0d", code, k), data_av, (k >= lvl(code)) ? 1 : 0);
         end
      end

      // R7 pulse form, threshold 4
      trig_sel = 2'd1; av_pulse_mode = 1'b1;
      clear();
      for (int k = 0; k < 3; k++) begin
         step(1'b1, 1'b0, 10'(k));
         check("R7 below", data_av, 0);
      end
      step(1'b1, 1'b0, 10'd3);
      check("R7 pulse on crossing", data_av, 1);
      step(1'b0, 1'b0, '0);
      check("R7 pulse ends", data_av, 0);
      step(1'b1, 1'b0, 10'd4);
      check("R7 no pulse above", data_av, 0);
      step(1'b0, 1'b1, '0);
      step(1'b0, 1'b1, '0);
      check("R7 below again", data_av, 0);
      step(1'b1, 1'b0, 10'd5);
      check("R7 second pulse", data_av, 1);
      step(1'b0, 1'b0, '0);
      check("R7 second pulse ends", data_av, 0);

      // R8 polarity, level form, threshold 1
      av_pulse_mode = 1'b0; av_active_low = 1'b1; trig_sel = 2'd0;
      clear();
      check("R8 inactive high", data_av, 1);
      step(1'b1, 1'b0, 10'd7);
      check("R8 active low", data_av, 0);

      done = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule